// File: doc/BRIEF.md
# Sample-to-Sample Slew Check Filter

This block sits between a converter's result register and the rest of the chip and polices the step size between consecutive output codes. Every valid code is compared against the last code the filter accepted. A code that is equal to that reference or one step above or below it is delivered unchanged and becomes the new reference. A code outside that window is flagged as abnormal, and the filter delivers the held reference code in its place. This suppresses isolated spikes that a tampered or faulty result path would inject.

Because a real input can make a genuine large step, the filter counts consecutive rejections and, after a parameterised number of them, gives in and takes the incoming code as the new reference. A sticky alarm records that any abnormal sample has been seen since reset. All outputs are registered, so every delivered code appears one clock after the strobe that carried it.

Top module: `slew_guard`

## Requirements
- R1: While and directly after synchronous reset, out_valid, out_abnormal and alarm are 0 and out_code is 0.
- R2: The first valid code after reset is delivered unchanged with out_abnormal 0 and becomes the reference, whatever its value.
- R3: A valid code equal to the reference, or greater or smaller by exactly 1, is delivered unchanged with out_abnormal 0 and becomes the new reference.
- R4: A valid code more than 1 away from the reference is delivered as the reference code with out_abnormal 1, and the reference keeps its value (a following code is judged against the old reference).
- R5: The window does not wrap at the code range ends: with CODE_W = 6, code 63 after reference 0 and code 0 after reference 63 are both abnormal.
- R6: out_valid is 1 exactly in the cycle after a cycle with in_valid 1; on cycles without a strobe out_valid and out_abnormal are 0 and out_code keeps its last value.
- R7: alarm rises together with the first abnormal output and stays 1 until reset.
- R8: When RESYNC_LIMIT (default 4) consecutive valid codes are rejected, the last of them is delivered unchanged, still with out_abnormal 1, becomes the reference, and the rejection count restarts; any accepted code also restarts the count.
- R9: Cycles without in_valid neither change the reference nor break a run of consecutive rejections.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Strobe marking a new raw code |
| in_code | input | CODE_W | Raw converter code |
| out_valid | output | 1 | Strobe marking a delivered code, one cycle after in_valid |
| out_code | output | CODE_W | Filtered code |
| out_abnormal | output | 1 | The delivered sample broke the step rule |
| alarm | output | 1 | Sticky record of any abnormal sample since reset |

## Verification
The hardest situation to reach is the resynchronisation edge: it needs a run of exactly RESYNC_LIMIT rejected codes with no accepted code between them, and it must be told apart from a run one short of the limit followed by an accepted code. The stimulus builds runs of three rejections that are broken by an in-window code, runs interrupted by idle cycles, and a full run of four, then checks the following code against the newly taken reference. The range ends are reached by resetting and seeding with 0 or 63 so that the wrap cases can be driven directly.

// File: rtl/slew_pkg.sv
package slew_pkg;
  // Source chosen for the delivered code on a valid sample
  typedef enum logic [1:0] {
    SEL_SEED   = 2'd0,
    SEL_PASS   = 2'd1,
    SEL_HOLD   = 2'd2,
    SEL_RESYNC = 2'd3
  } sel_e;
endpackage

// File: rtl/slew_window_cmp.sv
module slew_window_cmp #(
  parameter int CODE_W = 6
) (
  input  logic [CODE_W-1:0] cand,
  input  logic [CODE_W-1:0] ref_code,
  output logic              in_window
);
  localparam int EXT_W = CODE_W + 1;

  logic [EXT_W-1:0] cand_x, ref_x;

  // Widened arithmetic so the +/-1 test never wraps at the range ends
  always_comb begin
    cand_x    = {1'b0, cand};
    ref_x     = {1'b0, ref_code};
    in_window = (cand_x == ref_x) ||
                (cand_x == ref_x + EXT_W'(1)) ||
                (cand_x + EXT_W'(1) == ref_x);
  end
endmodule

// File: rtl/slew_reject_ctr.sv
module slew_reject_ctr #(
  parameter int LIMIT = 4,
  localparam int CNT_W = $clog2(LIMIT + 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             smp_valid,
  input  logic             smp_reject,
  output logic             at_limit,
  output logic [CNT_W-1:0] count
);
  logic [CNT_W-1:0] cnt_q;

  assign at_limit = smp_valid && smp_reject && (cnt_q == CNT_W'(LIMIT - 1));
  assign count    = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
    end else if (smp_valid) begin
      if (!smp_reject || at_limit) cnt_q <= '0;
      else                         cnt_q <= cnt_q + CNT_W'(1);
    end
  end
endmodule

// File: rtl/slew_guard.sv
module slew_guard
  import slew_pkg::*;
#(
  parameter int CODE_W       = 6,
  parameter int RESYNC_LIMIT = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [CODE_W-1:0] in_code,
  output logic              out_valid,
  output logic [CODE_W-1:0] out_code,
  output logic              out_abnormal,
  output logic              alarm
);
  localparam int CNT_W = $clog2(RESYNC_LIMIT + 1);

  logic [CODE_W-1:0] ref_q;
  logic              seeded_q;
  logic              in_win;
  logic              rejected;
  logic              hit_limit;
  logic [CNT_W-1:0]  rej_cnt;
  sel_e              sel;

  slew_window_cmp #(.CODE_W(CODE_W)) win_i (
    .cand      (in_code),
    .ref_code  (ref_q),
    .in_window (in_win)
  );

  assign rejected = seeded_q && !in_win;

  slew_reject_ctr #(.LIMIT(RESYNC_LIMIT)) ctr_i (
    .clk        (clk),
    .rst        (rst),
    .smp_valid  (in_valid),
    .smp_reject (rejected),
    .at_limit   (hit_limit),
    .count      (rej_cnt)
  );

  always_comb begin
    if (!seeded_q)      sel = SEL_SEED;
    else if (!rejected) sel = SEL_PASS;
    else if (hit_limit) sel = SEL_RESYNC;
    else                sel = SEL_HOLD;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_code     <= '0;
      out_abnormal <= 1'b0;
      alarm        <= 1'b0;
      ref_q        <= '0;
      seeded_q     <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_abnormal <= rejected;
        alarm        <= alarm | rejected;
        if (sel == SEL_HOLD) begin
          out_code <= ref_q;
        end else begin
          out_code <= in_code;
          ref_q    <= in_code;
          seeded_q <= 1'b1;
        end
      end else begin
        out_abnormal <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/slew_guard_chk.sv
module slew_guard_chk #(
  parameter int CODE_W = 6,
  parameter int LIMIT  = 4,
  parameter int CNT_W  = 3
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [CODE_W-1:0] in_code,
  input logic              out_valid,
  input logic [CODE_W-1:0] out_code,
  input logic              out_abnormal,
  input logic              alarm,
  input logic [CODE_W-1:0] ref_q,
  input logic              seeded_q,
  input logic [CNT_W-1:0]  rej_cnt
);
  localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

  // R6: strobe delay of one cycle
  a_r6_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);
  a_r6_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> (!out_valid && !out_abnormal && $stable(out_code)));

  // R3: a clean output is the code presented one cycle earlier
  a_r3_clean_passes: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_abnormal) |-> (out_code == $past(in_code)));

  // R4: an abnormal output is the held reference or a resync code
  a_r4_abn_value: assert property (@(posedge clk) disable iff (rst)
    (out_valid && out_abnormal) |-> (out_code == $past(ref_q) || out_code == $past(in_code)));

  // R5: no wrap at either range end
  a_r5_no_wrap_up: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seeded_q && ref_q == '0 && in_code == TOP) |=> out_abnormal);
  a_r5_no_wrap_down: assert property (@(posedge clk) disable iff (rst)
    (in_valid && seeded_q && ref_q == TOP && in_code == '0) |=> out_abnormal);

  // R7: alarm is sticky and set by abnormal outputs
  a_r7_alarm_sticky: assert property (@(posedge clk) disable iff (rst)
    alarm |=> alarm);
  a_r7_alarm_covers: assert property (@(posedge clk) disable iff (rst)
    out_abnormal |-> alarm);

  // R8: the rejection run never reaches the limit value
  a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
    rej_cnt < CNT_W'(LIMIT));

  // R9: reference holds across idle cycles
  a_r9_ref_idle: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> ($stable(ref_q) && $stable(rej_cnt)));
endmodule

bind slew_guard slew_guard_chk #(
  .CODE_W (CODE_W),
  .LIMIT  (RESYNC_LIMIT),
  .CNT_W  (CNT_W)
) chk_i (
  .clk          (clk),
  .rst          (rst),
  .in_valid     (in_valid),
  .in_code      (in_code),
  .out_valid    (out_valid),
  .out_code     (out_code),
  .out_abnormal (out_abnormal),
  .alarm        (alarm),
  .ref_q        (ref_q),
  .seeded_q     (seeded_q),
  .rej_cnt      (rej_cnt)
);

// File: tb/slew_guard_tb_top.sv
module slew_guard_tb_top;
  localparam int CODE_W = 6;
  localparam int LIMIT  = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [CODE_W-1:0] in_code = '0;
  logic              out_valid;
  logic [CODE_W-1:0] out_code;
  logic              out_abnormal;
  logic              alarm;

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 0;

  // Bench-side expectation state
  int  m_ref;
  bit  m_seeded;
  int  m_cnt;
  bit  m_alarm;
  int  m_last_out;

  always #4 clk = ~clk;

  slew_guard #(.CODE_W(CODE_W), .RESYNC_LIMIT(LIMIT)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_code(in_code),
    .out_valid(out_valid), .out_code(out_code),
    .out_abnormal(out_abnormal), .alarm(alarm)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    m_ref = 0; m_seeded = 0; m_cnt = 0; m_alarm = 0; m_last_out = 0;
  endtask

  // Presents one code at a negedge and checks the registered result a cycle later
  task automatic send(input int code, input string req);
    int  exp_code;
    bit  exp_abn;
    bit  ok_win;
    in_valid = 1'b1;
    in_code  = CODE_W'(code);
    ok_win = (code == m_ref) || (code == m_ref + 1) || (code == m_ref - 1);
    if (!m_seeded || ok_win) begin
      exp_code = code; exp_abn = 0; m_ref = code; m_seeded = 1; m_cnt = 0;
    end else if (m_cnt + 1 == LIMIT) begin
      exp_code = code; exp_abn = 1; m_ref = code; m_cnt = 0;
    end else begin
      exp_code = m_ref; exp_abn = 1; m_cnt++;
    end
    m_alarm = m_alarm | exp_abn;
    m_last_out = exp_code;
    @(negedge clk);
    in_valid = 1'b0;
    chk(out_valid == 1'b1, req, "out_valid", int'(out_valid), 1);
    chk(int'(out_code) == exp_code, req, "out_code", int'(out_code), exp_code);
    chk(out_abnormal == exp_abn, req, "out_abnormal", int'(out_abnormal), int'(exp_abn));
    chk(alarm == m_alarm, req, "alarm", int'(alarm), int'(m_alarm));
  endtask

  task automatic idle(input int n, input string req);
    for (int i = 0; i < n; i++) begin
      in_code = CODE_W'(i * 17 + 5);
      @(negedge clk);
      chk(out_valid == 1'b0, req, "idle out_valid", int'(out_valid), 0);
      chk(out_abnormal == 1'b0, req, "idle out_abnormal", int'(out_abnormal), 0);
      chk(int'(out_code) == m_last_out, req, "idle out_code held", int'(out_code), m_last_out);
    end
  endtask

  task automatic t_reset_state();
    do_reset();
    chk(out_valid == 0, "R1", "out_valid", int'(out_valid), 0);
    chk(out_abnormal == 0, "R1", "out_abnormal", int'(out_abnormal), 0);
    chk(alarm == 0, "R1", "alarm", int'(alarm), 0);
    chk(out_code == '0, "R1", "out_code", int'(out_code), 0);
  endtask

  task automatic t_seed_and_window();
    send(40, "R2");            // far from 0, still accepted as seed
    send(41, "R3");
    send(41, "R3");
    send(40, "R3");
    send(39, "R3");
  endtask

  task automatic t_reject();
    send(20, "R4");            // held at 39, alarm rises (R7)
    send(38, "R4");            // judged against 39, not 20
    send(36, "R4");
    send(37, "R3");
  endtask

  task automatic t_idle_gap();
    idle(3, "R6");
    send(60, "R9");            // rejection 1
    idle(2, "R9");
    send(60, "R9");            // rejection 2
    send(38, "R9");            // ref still 37 after idle
  endtask

  task automatic t_resync();
    send(10, "R8");
    send(10, "R8");
    send(10, "R8");
    send(37, "R8");            // accepted, run restarts
    send(10, "R8");
    send(10, "R8");
    idle(1, "R9");
    send(10, "R8");
    send(10, "R8");            // fourth: taken through
    send(11, "R8");            // judged against new reference
    send(30, "R8");
  endtask

  task automatic t_wrap();
    do_reset();
    chk(alarm == 0, "R7", "alarm after reset", int'(alarm), 0);
    send(0, "R5");
    send(63, "R5");
    send(1, "R5");
    do_reset();
    send(63, "R5");
    send(0, "R5");
    send(62, "R5");
  endtask

  initial begin
    t_reset_state();
    t_seed_and_window();
    t_reject();
    t_idle_gap();
    t_resync();
    t_wrap();
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
      $finish;
    end
  end
endmodule